// File: doc/BRIEF.md
# Calendar Clock Core

This block keeps the time and date for a real-time clock. It holds seconds, minutes, hours, day of week, day of month, month and a two-digit year. On each one-second tick it moves them forward by one second, and carries into the next field as each one wraps. Every field is held in the number format chosen by a mode input: packed BCD (two decimal digits in one byte) or plain binary. Hours can run over a 24-hour day, or over a 12-hour day with a PM flag.

Three alarm bytes hold a target second, minute and hour. When the time just written by an update matches all three, the block gives a one-cycle alarm pulse. An alarm byte of C0h or higher matches any value. Software reaches all ten bytes through a simple register port: an address, write data with a write strobe, and a combinational read. A freeze input stops ticks from taking effect while new values are loaded. Each update shows a one-cycle busy window and is followed by a one-cycle completion pulse.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, every register reads 00h except day of week, date and month, which read 01h. The outputs busy, done and alarm are low.
- R2: Register addresses: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 seconds alarm, 8 minutes alarm, 9 hours alarm. A write stores the byte as given. Addresses 10 to 15 read 00h, and writes to them change nothing.
- R3: Seconds and minutes run from 0 to 59 and then wrap to 0 with a carry. The top value is 59h in BCD mode (mode_bin=0) and 3Bh in binary mode (mode_bin=1).
- R4: In 24-hour mode (mode_24h=1), the hour wraps from 23 to 0 and advances the day. Day of week runs 1 to 7, then back to 1. Month wraps from 12 to 1 and advances the year. Year wraps from 99 to 0.
- R5: The date wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4, and 28 days otherwise. The other months have 31 days.
- R6: In 12-hour mode (mode_24h=0), bit 7 of the hour is the PM flag and bits 6:0 hold 1 to 12. The hour 11 AM goes to 12 PM (92h in BCD). 12 PM goes to 1 PM (81h). 11 PM goes to 12 AM (12h) and advances the day. In binary mode, 12 PM (8Ch) goes to 1 PM (81h).
- R7: alarm pulses for one cycle, in the same cycle as done, when the updated seconds, minutes and hours each match their alarm byte. It stays low otherwise.
- R8: An alarm byte whose top two bits are both 1 matches any value of its field.
- R9: While freeze is high, a tick does not start an update. Writes still take effect.
- R10: A tick sampled high, with freeze low and no update running, sets busy for exactly the next cycle. The new time appears at the edge that ends busy, and done is high for the one cycle after that edge.
- R11: A write presented while busy is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| mode_bin | input | 1 | 1 selects binary format, 0 selects BCD |
| mode_24h | input | 1 | 1 selects 24-hour mode, 0 selects 12-hour mode |
| freeze | input | 1 | Blocks ticks while high |
| wr_en | input | 1 | Write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for addr, combinational |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse after an update |
| alarm | output | 1 | One-cycle alarm match pulse |

## Verification
The hardest case to reach is a single tick whose carry runs through every field: 23:59:59 on 31 December of year 99, or the last day of February in a leap year. Waiting for this with real ticks would take years of simulated time. The stimulus instead writes the time one second short of each boundary and then gives one or two ticks. It repeats this in both number formats and both hour modes, and drives the alarm bytes to exact-match, partial-match and wildcard values. The test that a write is dropped during busy places the write in the single cycle after a tick.

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mode_bin,
  input  logic       mode_24h,
  input  logic       freeze,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done,
  output logic       alarm
);

  logic [7:0] sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
  logic [7:0] asec_q, amin_q, ahr_q;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic bin);
    dec = bin ? v[6:0] : 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] n, input logic bin);
    enc = bin ? {1'b0, n} : {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction

  function automatic logic hit(input logic [7:0] a, input logic [7:0] t);
    hit = (a[7:6] == 2'b11) || (a == t);
  endfunction

  logic [6:0] s, m, hv, dw, dt, mo, yr, dim;
  logic       pm;
  assign s  = dec(sec_q,  mode_bin);
  assign m  = dec(min_q,  mode_bin);
  assign hv = dec({1'b0, hr_q[6:0]}, mode_bin);
  assign pm = hr_q[7];
  assign dw = dow_q[6:0];
  assign dt = dec(date_q, mode_bin);
  assign mo = dec(mon_q,  mode_bin);
  assign yr = dec(yr_q,   mode_bin);

  logic c_s, c_m, c_h, c_d, c_mo, c_y;
  logic [7:0] h_nx;

  assign c_s = (s >= 7'd59);
  assign c_m = c_s && (m >= 7'd59);

  always_comb begin
    h_nx = hr_q;
    c_h  = 1'b0;
    if (c_m) begin
      if (mode_24h) begin
        if (hv >= 7'd23) begin
          h_nx = 8'h00;
          c_h  = 1'b1;
        end else begin
          h_nx = enc(hv + 7'd1, mode_bin);
        end
      end else if (hv >= 7'd12) begin
        h_nx = enc(7'd1, mode_bin) | {pm, 7'b0};
      end else if (hv == 7'd11) begin
        h_nx = enc(7'd12, mode_bin) | {~pm, 7'b0};
        c_h  = pm;
      end else begin
        h_nx = enc(hv + 7'd1, mode_bin) | {pm, 7'b0};
      end
    end
  end

  always_comb begin
    case (mo)
      7'd2:                       dim = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    dim = 7'd30;
      default:                    dim = 7'd31;
    endcase
  end

  assign c_d  = c_h  && (dt >= dim);
  assign c_mo = c_d  && (mo >= 7'd12);
  assign c_y  = c_mo && (yr >= 7'd99);

  logic [7:0] s_nx, m_nx, dw_nx, dt_nx, mo_nx, yr_nx;
  assign s_nx  = c_s  ? 8'h00 : enc(s + 7'd1, mode_bin);
  assign m_nx  = c_m  ? 8'h00 : (c_s ? enc(m + 7'd1, mode_bin) : min_q);
  assign dw_nx = c_h  ? ((dw >= 7'd7) ? 8'h01 : {1'b0, dw + 7'd1}) : dow_q;
  assign dt_nx = c_d  ? 8'h01 : (c_h ? enc(dt + 7'd1, mode_bin) : date_q);
  assign mo_nx = c_mo ? 8'h01 : (c_d ? enc(mo + 7'd1, mode_bin) : mon_q);
  assign yr_nx = c_y  ? 8'h00 : (c_mo ? enc(yr + 7'd1, mode_bin) : yr_q);

  logic match;
  assign match = hit(asec_q, s_nx) && hit(amin_q, m_nx) && hit(ahr_q, h_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      alarm  <= 1'b0;
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hr_q   <= 8'h00;
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      yr_q   <= 8'h00;
      asec_q <= 8'h00;
      amin_q <= 8'h00;
      ahr_q  <= 8'h00;
    end else begin
      busy  <= tick && !freeze && !busy;
      done  <= busy;
      alarm <= busy && match;
      if (busy) begin
        sec_q  <= s_nx;
        min_q  <= m_nx;
        hr_q   <= h_nx;
        dow_q  <= dw_nx;
        date_q <= dt_nx;
        mon_q  <= mo_nx;
        yr_q   <= yr_nx;
      end else if (wr_en) begin
        case (addr)
          4'd0: sec_q  <= wr_data;
          4'd1: min_q  <= wr_data;
          4'd2: hr_q   <= wr_data;
          4'd3: dow_q  <= wr_data;
          4'd4: date_q <= wr_data;
          4'd5: mon_q  <= wr_data;
          4'd6: yr_q   <= wr_data;
          4'd7: asec_q <= wr_data;
          4'd8: amin_q <= wr_data;
          4'd9: ahr_q  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      4'd0: rd_data = sec_q;
      4'd1: rd_data = min_q;
      4'd2: rd_data = hr_q;
      4'd3: rd_data = dow_q;
      4'd4: rd_data = date_q;
      4'd5: rd_data = mon_q;
      4'd6: rd_data = yr_q;
      4'd7: rd_data = asec_q;
      4'd8: rd_data = amin_q;
      4'd9: rd_data = ahr_q;
      default: rd_data = 8'h00;
    endcase
  end

  // R10
  busy_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));

  // R7
  alarm_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> done);

  // R9
  freeze_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !busy);

  // R11
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(wr_en && addr == 4'd0)) |=> $stable(sec_q));

endmodule

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, mode_bin = 1'b0, mode_24h = 1'b1, freeze = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic busy, done, alarm;

  rtc_calendar_core i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_bin(mode_bin), .mode_24h(mode_24h),
    .freeze(freeze), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .busy(busy), .done(done), .alarm(alarm));

  int total = 0, bad = 0, alarm_cnt = 0, busy_cnt = 0;
  string req = "R1";

  int mr[10];
  int dims[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};
  bit m_busy = 0, m_done = 0, m_alarm = 0;

  function automatic int bdec(int v, bit b);
    return b ? v : ((v >> 4) & 15) * 10 + (v & 15);
  endfunction
  function automatic int benc(int n, bit b);
    return b ? n : (n / 10) * 16 + (n % 10);
  endfunction
  function automatic bit mhit(int a, int t);
    return (a >= 192) || (a == t);
  endfunction

  task automatic m_reset();
    foreach (mr[i]) mr[i] = 0;
    mr[3] = 1; mr[4] = 1; mr[5] = 1;
    m_busy = 0; m_done = 0; m_alarm = 0;
  endtask

  task automatic m_advance();
    bit b = mode_bin;
    bit day = 0;
    int v, pm, dt, mo, y, dim;
    v = bdec(mr[0], b) + 1;
    if (v < 60) mr[0] = benc(v, b);
    else begin
      mr[0] = 0;
      v = bdec(mr[1], b) + 1;
      if (v < 60) mr[1] = benc(v, b);
      else begin
        mr[1] = 0;
        if (mode_24h) begin
          v = bdec(mr[2] & 127, b) + 1;
          if (v < 24) mr[2] = benc(v, b);
          else begin mr[2] = 0; day = 1; end
        end else begin
          pm = (mr[2] >> 7) & 1;
          v = bdec(mr[2] & 127, b);
          if (v == 12) v = 1;
          else begin
            v++;
            if (v == 12) begin pm = 1 - pm; day = (pm == 0); end
          end
          mr[2] = benc(v, b) + 128 * pm;
        end
      end
    end
    if (day) begin
      mr[3] = (mr[3] == 7) ? 1 : mr[3] + 1;
      dt = bdec(mr[4], b); mo = bdec(mr[5], b); y = bdec(mr[6], b);
      dim = dims[mo - 1];
      if (mo == 2 && y % 4 == 0) dim = 29;
      if (dt < dim) mr[4] = benc(dt + 1, b);
      else begin
        mr[4] = 1;
        if (mo < 12) mr[5] = benc(mo + 1, b);
        else begin
          mr[5] = 1;
          mr[6] = (y >= 99) ? 0 : benc(y + 1, b);
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      m_done = 0; m_alarm = 0;
      if (m_busy) begin
        m_advance();
        m_busy = 0; m_done = 1;
        m_alarm = mhit(mr[7], mr[0]) && mhit(mr[8], mr[1]) && mhit(mr[9], mr[2]);
      end else begin
        if (wr_en && addr < 10) mr[addr] = wr_data;
        if (tick && !freeze) m_busy = 1;
      end
    end
  end

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(req, rd_data, (addr < 10) ? 8'(mr[addr]) : 8'h00);
      chk("R10", {6'b0, busy, done}, {6'b0, m_busy, m_done});
      chk("R7", {7'b0, alarm}, {7'b0, m_alarm});
      if (alarm) alarm_cnt++;
      if (busy) busy_cnt++;
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1 wr_en = 1; addr = 4'(a); wr_data = 8'(d);
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic one_tick();
    @(posedge clk); #1 tick = 1;
    @(posedge clk); #1 tick = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic expect_rd(int a, int e, string r);
    @(posedge clk); #1 addr = 4'(a);
    @(negedge clk);
    chk(r, rd_data, 8'(e));
  endtask

  task automatic set_time(int s, int m, int h, int dw, int dt, int mo, int y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    req = "R1";
    for (int i = 0; i < 10; i++) expect_rd(i, (i >= 3 && i <= 5) ? 1 : 0, "R1");

    req = "R2";
    wr(12, 8'h55);
    expect_rd(12, 0, "R2");
    wr(7, 8'h3A);
    expect_rd(7, 8'h3A, "R2");

    req = "R3";
    mode_bin = 0; mode_24h = 1;
    set_time(8'h58, 8'h59, 8'h23, 7, 8'h31, 8'h12, 8'h99);
    one_tick();
    expect_rd(0, 8'h59, "R3");
    req = "R4";
    one_tick();
    expect_rd(0, 8'h00, "R3");
    expect_rd(1, 8'h00, "R3");
    expect_rd(2, 8'h00, "R4");
    expect_rd(3, 8'h01, "R4");
    expect_rd(4, 8'h01, "R4");
    expect_rd(5, 8'h01, "R4");
    expect_rd(6, 8'h00, "R4");

    req = "R5";
    mode_bin = 1;
    set_time(8'h3B, 8'h3B, 8'h17, 3, 8'h1C, 8'h02, 8'h04);
    one_tick();
    expect_rd(4, 8'h1D, "R5");
    expect_rd(0, 8'h00, "R3");
    set_time(8'h3B, 8'h3B, 8'h17, 4, 8'h1D, 8'h02, 8'h04);
    one_tick();
    expect_rd(4, 8'h01, "R5");
    expect_rd(5, 8'h03, "R5");
    mode_bin = 0;
    set_time(8'h59, 8'h59, 8'h23, 1, 8'h28, 8'h02, 8'h05);
    one_tick();
    expect_rd(4, 8'h01, "R5");
    expect_rd(5, 8'h03, "R5");
    set_time(8'h59, 8'h59, 8'h23, 2, 8'h30, 8'h04, 8'h21);
    one_tick();
    expect_rd(4, 8'h01, "R5");
    expect_rd(5, 8'h05, "R5");

    req = "R6";
    mode_24h = 0;
    set_time(8'h59, 8'h59, 8'h11, 2, 8'h10, 8'h05, 8'h20);
    one_tick();
    expect_rd(2, 8'h92, "R6");
    wr(0, 8'h59); wr(1, 8'h59);
    one_tick();
    expect_rd(2, 8'h81, "R6");
    set_time(8'h59, 8'h59, 8'h91, 2, 8'h10, 8'h05, 8'h20);
    one_tick();
    expect_rd(2, 8'h12, "R6");
    expect_rd(4, 8'h11, "R6");
    mode_bin = 1;
    set_time(8'h3B, 8'h3B, 8'h8C, 2, 8'h0A, 8'h05, 8'h14);
    one_tick();
    expect_rd(2, 8'h81, "R6");

    req = "R8";
    mode_bin = 0; mode_24h = 1;
    wr(7, 8'h05); wr(8, 8'hC0); wr(9, 8'hFF);
    set_time(8'h04, 8'h20, 8'h10, 3, 8'h15, 8'h06, 8'h22);
    a0 = alarm_cnt;
    one_tick();
    chk("R8", 8'(alarm_cnt - a0), 8'd1);
    a0 = alarm_cnt;
    one_tick();
    chk("R7", 8'(alarm_cnt - a0), 8'd0);
    req = "R7";
    wr(7, 8'h07); wr(8, 8'h20); wr(9, 8'h10);
    a0 = alarm_cnt;
    one_tick();
    chk("R7", 8'(alarm_cnt - a0), 8'd1);
    wr(0, 8'h06); wr(8, 8'h21);
    a0 = alarm_cnt;
    one_tick();
    chk("R7", 8'(alarm_cnt - a0), 8'd0);

    req = "R9";
    freeze = 1;
    wr(0, 8'h30);
    a0 = busy_cnt;
    one_tick(); one_tick(); one_tick();
    chk("R9", 8'(busy_cnt - a0), 8'd0);
    expect_rd(0, 8'h30, "R9");
    wr(0, 8'h31);
    expect_rd(0, 8'h31, "R9");
    freeze = 0;

    req = "R11";
    wr(0, 8'h10);
    @(posedge clk); #1 tick = 1;
    @(posedge clk); #1 tick = 0; wr_en = 1; addr = 4'd0; wr_data = 8'h33;
    @(posedge clk); #1 wr_en = 0;
    expect_rd(0, 8'h11, "R11");

    req = "R10";
    a0 = busy_cnt;
    one_tick();
    chk("R10", 8'(busy_cnt - a0), 8'd1);
    expect_rd(0, 8'h12, "R10");

    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule